// File: doc/BRIEF.md
# Rotating-Priority Vectored Interrupt Controller

This block gathers 64 raw interrupt lines and sorts them onto eight request outputs: one IRQ line, one FIQ line and six auxiliary lines. Every source owns one control byte that turns it on or off, selects how it triggers (high level, rising edge, falling edge, or either edge) and chooses which of the eight outputs it drives. Edge events are held in status bits until software clears them by writing ones. Level sources show the registered input directly.

Software learns which IRQ source to service by reading a number register. The register holds the winning pending source, or 63 when no source is pending. Bit 31 of the upper status word tells a real source-63 request apart from that idle value. A second number register does the same job for FIQ. Each of the two arbiters runs in fixed mode, where the lowest number wins, or in rotating mode. In rotating mode the search starts one place above the last number that was read out, which spreads service evenly across busy sources.

The register bus is a simple single-cycle strobe interface. Read data depends combinationally on the address. Every access must be word aligned.

Top module: `prio_intc`

## Requirements
- R1: Source n (0 to 63) has a control byte in byte lane n%4 of the word at byte address 0x40+4*(n/4), and bit 3 of that byte is its enable. While the enable is clear, the source drives no output and never wins arbitration, whatever its input does.
- R2: Control bits 2:0 select the output: 0 is irq_o, 1 is fiq_o, and 2 to 7 are aux_o[0] to aux_o[5]. An output is the OR of all enabled pending sources routed to it, and it follows one clock edge after the input is sampled.
- R3: With control bits 5 and 6 both clear, the source is active-high level and its status bit is the registered input. Bit 5 latches a rising edge and bit 6 latches a falling edge; with both set, either edge is latched. A latched event stays after the input returns.
- R4: Status for sources 0..31 is at 0x80 (bit n) and for sources 32..63 at 0x84 (bit n-32). Writing 1 to a latched edge bit clears it. Writing 0 leaves it unchanged. A new edge that arrives in the same cycle as the clear wins, and the bit stays set.
- R5: A read at 0x00 returns the winning IRQ source number in bits 5:0, or 63 when no IRQ source is pending. Bit 31 at 0x84 is 1 only when source 63 is really pending.
- R6: irq_o is high exactly when the IRQ arbiter has a winner.
- R7: With bit 6 of the IRQ priority register at 0x20 clear, the lowest-numbered enabled pending IRQ source wins, and repeated reads return the same number.
- R8: With bit 6 at 0x20 set, the search starts one above the number in bits 5:0 and wraps from 63 to 0. A read of 0x00 that returns a real winner stores that winner into bits 5:0. Software can write both fields, and a read of 0x20 returns them.
- R9: A read at 0x04 returns the FIQ winner. Its arbitration follows R7 and R8, governed by the FIQ priority register at 0x24.
- R10: After reset, all control bytes, status bits and priority registers read 0, all outputs are low, and 0x00 reads 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; reading 0x00 or 0x04 advances the matching rotation point |
| bus_addr | input | 8 | Byte address; bits 1:0 must be zero |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_i | input | 64 | Raw interrupt inputs |
| irq_o | output | 1 | IRQ request |
| fiq_o | output | 1 | FIQ request |
| aux_o | output | 6 | Auxiliary requests |

## Verification
If an edge latch is stuck or cleared by mistake, the routed output is wrong one edge after the event or the clear. The status word shows it on the next read. If the rotation point is corrupted, nothing changes at the outputs. It shows only in the order of numbers that successive reads of 0x00 return, so the bench reads several rounds and compares each number with a reference arbiter. A routing decode error shows on the wrong output pin one edge after the source rises.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
    localparam int SRC_N      = 64;
    localparam int NUM_W      = $clog2(SRC_N);
    localparam int DEST_N     = 8;
    localparam int DEST_W     = $clog2(DEST_N);
    localparam int BUS_W      = 32;
    localparam int LANES      = BUS_W / 8;
    localparam int CTL_WORDS  = SRC_N / LANES;
    localparam int CTL_WORD_W = $clog2(CTL_WORDS);
    localparam int STAT_WORDS = SRC_N / BUS_W;
    localparam int CFG_W      = NUM_W + 1;

    localparam int BIT_EN   = 3;
    localparam int BIT_RISE = 5;
    localparam int BIT_FALL = 6;

    localparam logic [NUM_W-1:0] IDLE_NUM = NUM_W'(SRC_N - 1);

    typedef logic [7:0] ctl_byte_t;
endpackage

// File: rtl/intc_src_bank.sv
module intc_src_bank
    import prio_intc_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [SRC_N-1:0]               src_i,
    input  logic                           ctl_we,
    input  logic [CTL_WORD_W-1:0]          ctl_word,
    input  logic [LANES-1:0]               be,
    input  logic [BUS_W-1:0]               wdata,
    input  logic [STAT_WORDS-1:0]          stat_we,
    output logic [SRC_N-1:0][7:0]          ctl_o,
    output logic [SRC_N-1:0]               stat_o,
    output logic [SRC_N-1:0]               pend_o
);
    typedef struct packed {
        logic [SRC_N-1:0]      lvl;
        logic [SRC_N-1:0]      evt;
        logic [SRC_N-1:0][7:0] ctl;
    } bank_t;

    bank_t s_q, s_d;
    logic [SRC_N-1:0] set_v, clr_v, edge_m;

    always_comb begin
        s_d     = s_q;
        s_d.lvl = src_i;
        for (int i = 0; i < SRC_N; i++) begin
            edge_m[i] = s_q.ctl[i][BIT_RISE] | s_q.ctl[i][BIT_FALL];
            set_v[i]  = (s_q.ctl[i][BIT_RISE] &  src_i[i] & ~s_q.lvl[i])
                      | (s_q.ctl[i][BIT_FALL] & ~src_i[i] &  s_q.lvl[i]);
            clr_v[i]  = stat_we[i / BUS_W] & be[(i % BUS_W) / 8] & wdata[i % BUS_W];
            s_d.evt[i] = edge_m[i] & (set_v[i] | (s_q.evt[i] & ~clr_v[i]));
            stat_o[i]  = edge_m[i] ? s_q.evt[i] : s_q.lvl[i];
            pend_o[i]  = stat_o[i] & s_q.ctl[i][BIT_EN];
        end
        if (ctl_we) begin
            for (int b = 0; b < LANES; b++) begin
                if (be[b]) begin
                    s_d.ctl[int'(ctl_word) * LANES + b] = wdata[8*b +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctl_o = s_q.ctl;

    // R3: a detected edge is latched at the next edge
    a_r3_edge_capture: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((s_q.evt & $past(set_v)) == $past(set_v)));

    // R4: a one written without a coincident edge clears the latch
    a_r4_w1c_clear: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((s_q.evt & $past(clr_v & ~set_v)) == '0));
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import prio_intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  pend_i,
    input  logic              take_i,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_o,
    output logic              found_o,
    output logic [NUM_W-1:0]  num_o
);
    typedef struct packed {
        logic             rot;
        logic [NUM_W-1:0] last;
    } arb_t;

    arb_t s_q, s_d;
    logic [NUM_W-1:0] start, idx, win;
    logic             hit;

    always_comb begin
        start = s_q.rot ? s_q.last + 1'b1 : '0;
        hit   = 1'b0;
        win   = IDLE_NUM;
        idx   = '0;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            idx = start + NUM_W'(i);
            if (pend_i[idx]) begin
                hit = 1'b1;
                win = idx;
            end
        end
        s_d = s_q;
        if (cfg_we) begin
            s_d.rot  = cfg_wdata[NUM_W];
            s_d.last = cfg_wdata[NUM_W-1:0];
        end else if (take_i && hit) begin
            s_d.last = win;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign found_o = hit;
    assign num_o   = win;
    assign cfg_o   = {s_q.rot, s_q.last};

    // R8: a read with a winner records that winner
    a_r8_ptr_update: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && found_o && !cfg_we) |=> (cfg_o[NUM_W-1:0] == $past(num_o)));

    // R7: a reported winner is always a pending source
    a_r7_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> pend_i[num_o]);
endmodule

// File: rtl/intc_router.sv
module intc_router
    import prio_intc_pkg::*;
(
    input  logic [SRC_N-1:0]              pend_i,
    input  logic [SRC_N-1:0][DEST_W-1:0]  dest_i,
    output logic [DEST_N-1:0][SRC_N-1:0]  route_o,
    output logic [DEST_N-1:0]             req_o
);
    for (genvar d = 0; d < DEST_N; d++) begin : g_dest
        always_comb begin
            for (int i = 0; i < SRC_N; i++) begin
                route_o[d][i] = pend_i[i] & (dest_i[i] == DEST_W'(d));
            end
        end
        assign req_o[d] = |route_o[d];
    end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import prio_intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [63:0]       src_i,
    output logic              irq_o,
    output logic              fiq_o,
    output logic [5:0]        aux_o
);
    localparam int ARB_N = 2;

    logic [SRC_N-1:0][7:0]        ctl;
    logic [SRC_N-1:0][DEST_W-1:0] dest;
    logic [SRC_N-1:0]             stat, pend;
    logic [DEST_N-1:0][SRC_N-1:0] route;
    logic [DEST_N-1:0]            req;
    logic                         aligned, ctl_sel;
    logic [STAT_WORDS-1:0]        stat_sel;
    logic [ARB_N-1:0]             num_sel, cfg_sel, found;
    logic [ARB_N-1:0][CFG_W-1:0]  cfg;
    logic [ARB_N-1:0][NUM_W-1:0]  num;

    always_comb begin
        aligned = (bus_addr[1:0] == 2'b00);
        ctl_sel = aligned && (bus_addr[7:6] == 2'b01);
        for (int w = 0; w < STAT_WORDS; w++) begin
            stat_sel[w] = aligned && (bus_addr[7:2] == 6'(8'h80 / 4 + w));
        end
        for (int a = 0; a < ARB_N; a++) begin
            num_sel[a] = aligned && (bus_addr[7:2] == 6'(a));
            cfg_sel[a] = aligned && (bus_addr[7:2] == 6'(8'h20 / 4 + a));
        end
        for (int i = 0; i < SRC_N; i++) dest[i] = ctl[i][DEST_W-1:0];
    end

    intc_src_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src_i),
        .ctl_we  (bus_wr && ctl_sel),
        .ctl_word(bus_addr[CTL_WORD_W+1:2]),
        .be      (bus_be),
        .wdata   (bus_wdata),
        .stat_we (stat_sel & {STAT_WORDS{bus_wr}}),
        .ctl_o   (ctl),
        .stat_o  (stat),
        .pend_o  (pend)
    );

    intc_router u_router (
        .pend_i (pend),
        .dest_i (dest),
        .route_o(route),
        .req_o  (req)
    );

    for (genvar a = 0; a < ARB_N; a++) begin : g_arb
        intc_arbiter u_arb (
            .clk      (clk),
            .rst_n    (rst_n),
            .pend_i   (route[a]),
            .take_i   (bus_rd && num_sel[a]),
            .cfg_we   (bus_wr && cfg_sel[a] && bus_be[0]),
            .cfg_wdata(bus_wdata[CFG_W-1:0]),
            .cfg_o    (cfg[a]),
            .found_o  (found[a]),
            .num_o    (num[a])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int a = 0; a < ARB_N; a++) begin
            if (num_sel[a]) bus_rdata = 32'(num[a]);
            if (cfg_sel[a]) bus_rdata = 32'(cfg[a]);
        end
        for (int w = 0; w < STAT_WORDS; w++) begin
            if (stat_sel[w]) bus_rdata = stat[BUS_W*w +: BUS_W];
        end
        if (ctl_sel) begin
            for (int b = 0; b < LANES; b++) begin
                bus_rdata[8*b +: 8] = ctl[int'(bus_addr[CTL_WORD_W+1:2]) * LANES + b];
            end
        end
    end

    assign irq_o = req[0];
    assign fiq_o = req[1];
    assign aux_o = req[DEST_N-1:2];

    // R6: the IRQ line agrees with the IRQ arbiter
    a_r6_irq_matches: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == found[0]);

    // R5: with no IRQ request the number register holds the idle value
    a_r5_idle_63: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (num[0] == IDLE_NUM));
endmodule

// File: tb/prio_intc_bench.sv
module prio_intc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [63:0] src_i = '0;
    logic        irq_o, fiq_o;
    logic [5:0]  aux_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    prio_intc u_prio_intc (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .src_i(src_i), .irq_o(irq_o),
        .fiq_o(fiq_o), .aux_o(aux_o)
    );

    // {source, control byte, expected outputs {aux5..aux0, fiq, irq}}
    localparam logic [23:0] ROUTE_TBL [0:7] = '{
        24'h05_08_01, 24'h09_09_02, 24'h14_0A_04, 24'h28_0F_80,
        24'h3F_0B_08, 24'h21_00_00, 24'h0C_0C_10, 24'h2E_0E_40
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_ctl(input int src, input logic [7:0] v);
        bus_write(8'(8'h40 + (src / 4) * 4), 32'(v) << (8 * (src % 4)), 4'(1 << (src % 4)));
    endtask

    task automatic drive(input int src, input logic v);
        @(negedge clk);
        src_i[src] = v;
        @(negedge clk);
    endtask

    function automatic logic [6:0] ref_pick(input logic [63:0] p, input bit rot, input logic [5:0] last);
        logic [5:0] s;
        s = rot ? last + 6'd1 : 6'd0;
        for (int i = 0; i < 64; i++) begin
            if (p[6'(s + 6'(i))]) return {1'b1, 6'(s + 6'(i))};
        end
        return {1'b0, 6'd63};
    endfunction

    function automatic logic [7:0] outs();
        return {aux_o, fiq_o, irq_o};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [63:0] pmask;
        logic [5:0]  last;
        logic [6:0]  pk;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        check("R10 outputs", 32'(outs()), 32'h0);
        bus_read(8'h00, rd); check("R10 irq number idle", rd, 32'd63);
        bus_read(8'h40, rd); check("R10 control word", rd, 32'h0);
        bus_read(8'h84, rd); check("R10 status high", rd, 32'h0);
        bus_read(8'h20, rd); check("R10 priority reg", rd, 32'h0);

        // R1 R2 R3 R5: routing table
        for (int k = 0; k < 8; k++) begin
            int src;
            logic [7:0] cb, ex;
            src = int'(ROUTE_TBL[k][23:16]);
            cb  = ROUTE_TBL[k][15:8];
            ex  = ROUTE_TBL[k][7:0];
            set_ctl(src, cb);
            drive(src, 1'b1);
            check("R2 routed outputs", 32'(outs()), 32'(ex));
            bus_read(8'h00, rd);
            check("R5 irq number", rd, ex[0] ? 32'(src) : 32'd63);
            bus_read(src < 32 ? 8'h80 : 8'h84, rd);
            check("R3 level status", 32'(rd[src % 32]), 32'd1);
            drive(src, 1'b0);
            set_ctl(src, 8'h00);
        end

        // R1: control byte readback in its lane
        set_ctl(6, 8'hA5);
        bus_read(8'h44, rd); check("R1 control lane", rd, 32'h00A5_0000);
        set_ctl(6, 8'h00);

        // R3 R4: rising edge latch, write zero, write one
        set_ctl(3, 8'h28);
        drive(3, 1'b1);
        check("R3 rising sets irq", 32'(irq_o), 32'd1);
        drive(3, 1'b0);
        check("R3 latch holds", 32'(irq_o), 32'd1);
        bus_write(8'h80, 32'h0, 4'hF);
        bus_read(8'h80, rd); check("R4 write zero keeps", rd, 32'h8);
        // R4: edge in same cycle as clear wins
        @(negedge clk);
        src_i[3] = 1'b1; bus_wr = 1'b1; bus_addr = 8'h80; bus_wdata = 32'h8; bus_be = 4'hF;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
        bus_read(8'h80, rd); check("R4 edge beats clear", rd, 32'h8);
        bus_write(8'h80, 32'h8, 4'hF);
        @(negedge clk);
        check("R4 w1c clears irq", 32'(irq_o), 32'd0);
        drive(3, 1'b0);
        set_ctl(3, 8'h00);

        // R3: falling edge on source 35
        set_ctl(35, 8'h48);
        drive(35, 1'b1);
        check("R3 falling ignores rise", 32'(irq_o), 32'd0);
        drive(35, 1'b0);
        check("R3 falling sets irq", 32'(irq_o), 32'd1);
        bus_read(8'h84, rd); check("R4 high status bit", rd, 32'h8);
        bus_write(8'h84, 32'h8, 4'hF);
        bus_read(8'h84, rd); check("R4 high status cleared", rd, 32'h0);
        set_ctl(35, 8'h00);

        // R1: disabling a level source masks it
        set_ctl(7, 8'h08);
        drive(7, 1'b1);
        check("R1 enabled level", 32'(irq_o), 32'd1);
        set_ctl(7, 8'h00);
        check("R1 masked level", 32'(irq_o), 32'd0);
        bus_read(8'h80, rd); check("R1 status still shows input", rd, 32'h80);
        drive(7, 1'b0);

        // R5: source 63 versus idle
        bus_read(8'h84, rd); check("R5 idle bit31", 32'(rd[31]), 32'd0);
        set_ctl(63, 8'h08);
        drive(63, 1'b1);
        bus_read(8'h00, rd); check("R5 source 63 number", rd, 32'd63);
        bus_read(8'h84, rd); check("R5 source 63 bit31", 32'(rd[31]), 32'd1);
        check("R6 irq for 63", 32'(irq_o), 32'd1);
        drive(63, 1'b0);
        set_ctl(63, 8'h00);

        // R7: fixed priority
        set_ctl(10, 8'h08); set_ctl(30, 8'h08); set_ctl(50, 8'h08);
        @(negedge clk);
        src_i[10] = 1'b1; src_i[30] = 1'b1; src_i[50] = 1'b1;
        @(negedge clk);
        pmask = '0; pmask[10] = 1'b1; pmask[30] = 1'b1; pmask[50] = 1'b1;
        for (int r = 0; r < 3; r++) begin
            bus_read(8'h00, rd); check("R7 fixed winner", rd, 32'd10);
        end

        // R8: rotating order
        bus_write(8'h20, 32'h40, 4'h1);
        last = 6'd0;
        for (int r = 0; r < 7; r++) begin
            pk = ref_pick(pmask, 1'b1, last);
            bus_read(8'h00, rd); check("R8 rotating winner", rd, 32'(pk[5:0]));
            last = pk[5:0];
        end
        bus_read(8'h20, rd); check("R8 pointer readback", rd, 32'h40 | 32'(last));
        // R8: wrap from 63 to 0
        bus_write(8'h20, 32'h40 | 32'd55, 4'h1);
        bus_read(8'h00, rd); check("R8 wrap winner", rd, 32'd10);
        set_ctl(10, 8'h00); set_ctl(30, 8'h00); set_ctl(50, 8'h00);
        @(negedge clk);
        src_i[10] = 1'b0; src_i[30] = 1'b0; src_i[50] = 1'b0;
        @(negedge clk);
        check("R6 irq low", 32'(irq_o), 32'd0);

        // R9: FIQ arbitration
        set_ctl(2, 8'h09); set_ctl(60, 8'h09);
        @(negedge clk);
        src_i[2] = 1'b1; src_i[60] = 1'b1;
        @(negedge clk);
        bus_read(8'h04, rd); check("R9 fiq fixed", rd, 32'd2);
        bus_read(8'h00, rd); check("R9 irq idle while fiq", rd, 32'd63);
        bus_write(8'h24, 32'h40 | 32'd2, 4'h1);
        bus_read(8'h04, rd); check("R9 fiq rotate", rd, 32'd60);
        bus_read(8'h04, rd); check("R9 fiq rotate wrap", rd, 32'd2);
        check("R2 fiq line", 32'(outs()), 32'h02);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule